// File: doc/BRIEF.md
# Auto-retransmit transmit controller

This block sequences the transmit side of a packet radio link that expects acknowledgements. When the radio is powered, the chip-enable level is high and the transmit FIFO holds a packet, the block lets the radio settle into transmit mode. It then issues a start strobe and allows the packet its air time. Unless the packet is flagged no-ack, it then turns the radio around to receive and opens an acknowledgement window.

An acknowledgement completes the packet and pops the FIFO entry. A missing acknowledgement sends the block into a programmable back-off, after which the packet is retransmitted. When the programmed number of retries is used up, the block gives up and flags a failure. The FIFO entry is kept so that it can be retried later.

All time intervals are given in microseconds and converted to clock cycles from a clock-frequency parameter. The intervals are: the turnaround settle time, the air time, the acknowledgement window and the back-off slot. Framing, CRC and the analog front end sit outside the block.

Top module: `arq_tx_ctrl`

## Requirements
- R1: After reset all strobes and event outputs are low and both the retry counter and the lost-packet counter read 0.
- R2: A packet is started only when power-up, chip-enable and FIFO-not-empty are all high in the idle state. The tx-start strobe follows one cycle later plus the settle interval.
- R3: After the air time of a packet without the no-ack flag, rx-enable is high for the settle interval followed by the acknowledgement window. It is never high together with tx-start.
- R4: An acknowledgement without payload during the window gives one cycle of done-event plus FIFO pop, with no receive event.
- R5: An acknowledgement carrying a payload raises the done-event and the receive event in the same cycle.
- R6: When the window closes without an acknowledgement, the retry counter increments and the block waits (D+1) back-off slots before a new settle interval and a retransmission. D is bits 7:4 of the retry setup byte.
- R7: When the window closes and the retry counter equals C (bits 3:0 of the setup byte), the block raises the failure event, returns to idle and does not pop the FIFO.
- R8: With C = 0 the first missed acknowledgement raises the failure event, with no retransmission.
- R9: The lost-packet counter adds one on each failure event, holds at 15 and is cleared to 0 by the clear input.
- R10: A packet carrying the no-ack flag raises the done-event and pop right after its air time, without rx-enable.
- R11: Dropping power-up returns the block to idle from any state, with no event raised.
- R12: With chip-enable low, a non-empty FIFO is not sent. With chip-enable high, queued packets are sent back to back until the FIFO is empty.
- R13: The retry counter restarts from 0 at the start of every new packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_up_i | input | 1 | Radio powered; low aborts any sequence |
| ce_i | input | 1 | Chip-enable level, permits starting a packet |
| fifo_ne_i | input | 1 | Transmit FIFO holds at least one packet |
| no_ack_i | input | 1 | Head packet needs no acknowledgement |
| ack_rx_i | input | 1 | Acknowledgement received strobe |
| ack_pld_i | input | 1 | Received acknowledgement carries a payload |
| retr_setup_i | input | 8 | Back-off slots field [7:4], retry limit field [3:0] |
| clr_lost_i | input | 1 | Clears the lost-packet counter |
| tx_start_o | output | 1 | One-cycle strobe: start sending the head packet |
| rx_en_o | output | 1 | Radio in receive for the acknowledgement |
| pop_o | output | 1 | One-cycle strobe: drop the FIFO head |
| tx_ds_o | output | 1 | Packet-done event |
| rx_dr_o | output | 1 | Payload-received event |
| max_rt_o | output | 1 | Retry-limit-reached event |
| retry_cnt_o | output | 4 | Retransmissions of the current packet |
| lost_cnt_o | output | 4 | Saturating count of failed packets |

## Verification
The bound checker watches several invariants on every cycle:
- a receive event never appears without the done-event;
- a failure never pops or completes;
- tx-start and rx-enable never overlap;
- a dropped power-up silences everything on the next cycle;
- the lost-packet counter steps by exactly one or clears.

Only the bench scenarios can show the exact timing. That covers the settle, air, window and back-off lengths, the retry limit reached for a given setup byte, the restart of the retry counter, back-to-back draining and saturation at 15. The bench shows these by comparing every output with its own cycle model.

// File: rtl/arq_tx_pkg.sv
`timescale 1ns/1ps
package arq_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TX_SETTLE,
        ST_AIR,
        ST_RX_SETTLE,
        ST_ACK_WAIT,
        ST_BACKOFF
    } arq_state_e;

    typedef struct packed {
        logic tx_ds;
        logic rx_dr;
        logic max_rt;
        logic pop;
    } arq_evt_t;

    localparam int RETRY_W = 4;

    // microseconds to clock cycles, never less than one cycle
    function automatic int us_to_cyc(input int us, input int khz);
        int c;
        c = (us * khz) / 1000;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int backoff_cyc(input logic [RETRY_W-1:0] slots, input int slot_cyc);
        return (int'(slots) + 1) * slot_cyc;
    endfunction

    function automatic logic [RETRY_W-1:0] setup_delay(input logic [7:0] setup);
        return setup[7:4];
    endfunction

    function automatic logic [RETRY_W-1:0] setup_limit(input logic [7:0] setup);
        return setup[3:0];
    endfunction

endpackage

// File: rtl/arq_cdown.sv
`timescale 1ns/1ps
module arq_cdown #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero_o
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)              cnt_q <= '0;
        else if (load)        cnt_q <= load_val;
        else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/arq_sat_ctr.sv
`timescale 1ns/1ps
module arq_sat_ctr #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    input  logic         clr,
    output logic [W-1:0] val_o
);
    always_ff @(posedge clk) begin
        if (rst || clr)                         val_o <= '0;
        else if (inc && (val_o != {W{1'b1}}))   val_o <= val_o + 1'b1;
    end
endmodule

// File: rtl/arq_seq_fsm.sv
`timescale 1ns/1ps
module arq_seq_fsm
    import arq_tx_pkg::*;
#(
    parameter int SETTLE_CYC = 5,
    parameter int AIR_CYC    = 4,
    parameter int WAIT_CYC   = 10,
    parameter int SLOT_CYC   = 10,
    parameter int CNT_W      = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               pwr_up,
    input  logic               ce,
    input  logic               fifo_ne,
    input  logic               no_ack,
    input  logic               ack_rx,
    input  logic               ack_pld,
    input  logic [RETRY_W-1:0] delay_slots,
    input  logic [RETRY_W-1:0] retry_limit,
    input  logic               tmr_zero,
    output logic               tmr_load,
    output logic [CNT_W-1:0]   tmr_val,
    output arq_state_e         state_o,
    output arq_evt_t           evt_o,
    output logic               tx_start_o,
    output logic [RETRY_W-1:0] retry_o,
    output logic               lost_inc_o
);
    arq_state_e         st_q, st_n;
    arq_evt_t           evt_n;
    logic               start_n;
    logic [RETRY_W-1:0] retry_n;

    always_comb begin
        st_n       = st_q;
        tmr_load   = 1'b0;
        tmr_val    = '0;
        evt_n      = '0;
        start_n    = 1'b0;
        retry_n    = retry_o;
        lost_inc_o = 1'b0;
        if (!pwr_up) begin
            st_n = ST_IDLE;
        end else begin
            unique case (st_q)
                ST_IDLE: if (ce && fifo_ne) begin
                    st_n     = ST_TX_SETTLE;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(SETTLE_CYC - 1);
                    retry_n  = '0;
                end
                ST_TX_SETTLE: if (tmr_zero) begin
                    st_n     = ST_AIR;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(AIR_CYC - 1);
                    start_n  = 1'b1;
                end
                ST_AIR: if (tmr_zero) begin
                    if (no_ack) begin
                        st_n        = ST_IDLE;
                        evt_n.tx_ds = 1'b1;
                        evt_n.pop   = 1'b1;
                    end else begin
                        st_n     = ST_RX_SETTLE;
                        tmr_load = 1'b1;
                        tmr_val  = CNT_W'(SETTLE_CYC - 1);
                    end
                end
                ST_RX_SETTLE: if (tmr_zero) begin
                    st_n     = ST_ACK_WAIT;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(WAIT_CYC - 1);
                end
                ST_ACK_WAIT: begin
                    if (ack_rx) begin
                        st_n        = ST_IDLE;
                        evt_n.tx_ds = 1'b1;
                        evt_n.rx_dr = ack_pld;
                        evt_n.pop   = 1'b1;
                    end else if (tmr_zero) begin
                        if (retry_o == retry_limit) begin
                            st_n         = ST_IDLE;
                            evt_n.max_rt = 1'b1;
                            lost_inc_o   = 1'b1;
                        end else begin
                            st_n     = ST_BACKOFF;
                            retry_n  = retry_o + 1'b1;
                            tmr_load = 1'b1;
                            tmr_val  = CNT_W'(backoff_cyc(delay_slots, SLOT_CYC) - 1);
                        end
                    end
                end
                ST_BACKOFF: if (tmr_zero) begin
                    st_n     = ST_TX_SETTLE;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(SETTLE_CYC - 1);
                end
                default: st_n = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= ST_IDLE;
            evt_o      <= '0;
            tx_start_o <= 1'b0;
            retry_o    <= '0;
        end else begin
            st_q       <= st_n;
            evt_o      <= evt_n;
            tx_start_o <= start_n;
            retry_o    <= retry_n;
        end
    end

    assign state_o = st_q;
endmodule

// File: rtl/arq_tx_ctrl.sv
`timescale 1ns/1ps
module arq_tx_ctrl
    import arq_tx_pkg::*;
#(
    parameter int CLK_KHZ     = 200_000,
    parameter int SETTLE_US   = 130,
    parameter int AIR_US      = 100,
    parameter int ACK_WAIT_US = 250,
    parameter int SLOT_US     = 250
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pwr_up_i,
    input  logic       ce_i,
    input  logic       fifo_ne_i,
    input  logic       no_ack_i,
    input  logic       ack_rx_i,
    input  logic       ack_pld_i,
    input  logic [7:0] retr_setup_i,
    input  logic       clr_lost_i,
    output logic       tx_start_o,
    output logic       rx_en_o,
    output logic       pop_o,
    output logic       tx_ds_o,
    output logic       rx_dr_o,
    output logic       max_rt_o,
    output logic [3:0] retry_cnt_o,
    output logic [3:0] lost_cnt_o
);
    localparam int SETTLE_CYC = us_to_cyc(SETTLE_US, CLK_KHZ);
    localparam int AIR_CYC    = us_to_cyc(AIR_US, CLK_KHZ);
    localparam int WAIT_CYC   = us_to_cyc(ACK_WAIT_US, CLK_KHZ);
    localparam int SLOT_CYC   = us_to_cyc(SLOT_US, CLK_KHZ);
    localparam int BACK_MAX   = (1 << RETRY_W) * SLOT_CYC;
    localparam int MAX_A      = (SETTLE_CYC > AIR_CYC) ? SETTLE_CYC : AIR_CYC;
    localparam int MAX_B      = (WAIT_CYC > BACK_MAX) ? WAIT_CYC : BACK_MAX;
    localparam int MAX_CYC    = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W      = $clog2(MAX_CYC + 1);

    logic             tmr_load, tmr_zero, lost_inc;
    logic [CNT_W-1:0] tmr_val;
    arq_state_e       state;
    arq_evt_t         evt;

    arq_cdown #(.W(CNT_W)) tmr_i (
        .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .zero_o(tmr_zero)
    );

    arq_seq_fsm #(
        .SETTLE_CYC(SETTLE_CYC), .AIR_CYC(AIR_CYC), .WAIT_CYC(WAIT_CYC),
        .SLOT_CYC(SLOT_CYC), .CNT_W(CNT_W)
    ) fsm_i (
        .clk(clk), .rst(rst), .pwr_up(pwr_up_i), .ce(ce_i), .fifo_ne(fifo_ne_i),
        .no_ack(no_ack_i), .ack_rx(ack_rx_i), .ack_pld(ack_pld_i),
        .delay_slots(setup_delay(retr_setup_i)), .retry_limit(setup_limit(retr_setup_i)),
        .tmr_zero(tmr_zero), .tmr_load(tmr_load), .tmr_val(tmr_val),
        .state_o(state), .evt_o(evt), .tx_start_o(tx_start_o),
        .retry_o(retry_cnt_o), .lost_inc_o(lost_inc)
    );

    arq_sat_ctr #(.W(4)) lost_i (
        .clk(clk), .rst(rst), .inc(lost_inc), .clr(clr_lost_i), .val_o(lost_cnt_o)
    );

    assign rx_en_o  = (state == ST_RX_SETTLE) || (state == ST_ACK_WAIT);
    assign pop_o    = evt.pop;
    assign tx_ds_o  = evt.tx_ds;
    assign rx_dr_o  = evt.rx_dr;
    assign max_rt_o = evt.max_rt;
endmodule

// File: rtl/arq_tx_checker.sv
`timescale 1ns/1ps
module arq_tx_checker (
    input logic       clk,
    input logic       rst,
    input logic       pwr_up_i,
    input logic       clr_lost_i,
    input logic       tx_start_o,
    input logic       rx_en_o,
    input logic       pop_o,
    input logic       tx_ds_o,
    input logic       rx_dr_o,
    input logic       max_rt_o,
    input logic [3:0] lost_cnt_o
);
    assert_dr_needs_ds_R5: assert property (@(posedge clk) disable iff (rst)
        rx_dr_o |-> tx_ds_o);

    assert_pop_only_done_R4: assert property (@(posedge clk) disable iff (rst)
        pop_o |-> tx_ds_o);

    assert_fail_keeps_entry_R7: assert property (@(posedge clk) disable iff (rst)
        max_rt_o |-> (!pop_o && !tx_ds_o));

    assert_start_not_rx_R3: assert property (@(posedge clk) disable iff (rst)
        tx_start_o |-> !rx_en_o);

    assert_abort_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        !pwr_up_i |=> (!tx_start_o && !rx_en_o && !tx_ds_o && !max_rt_o));

    assert_lost_clear_R9: assert property (@(posedge clk) disable iff (rst)
        clr_lost_i |=> (lost_cnt_o == 4'd0));

    assert_lost_step_R9: assert property (@(posedge clk) disable iff (rst)
        (max_rt_o && !$past(clr_lost_i) && ($past(lost_cnt_o) != 4'hF))
            |-> (lost_cnt_o == $past(lost_cnt_o) + 4'd1));
endmodule

bind arq_tx_ctrl arq_tx_checker chk_i (
    .clk(clk), .rst(rst), .pwr_up_i(pwr_up_i), .clr_lost_i(clr_lost_i),
    .tx_start_o(tx_start_o), .rx_en_o(rx_en_o), .pop_o(pop_o), .tx_ds_o(tx_ds_o),
    .rx_dr_o(rx_dr_o), .max_rt_o(max_rt_o), .lost_cnt_o(lost_cnt_o)
);

// File: tb/arq_tx_ctrl_tb_top.sv
`timescale 1ns/1ps
module arq_tx_ctrl_tb_top;
    localparam int KHZ    = 40;
    localparam int SET_C  = 130 * KHZ / 1000;   // 5
    localparam int AIR_C  = 100 * KHZ / 1000;   // 4
    localparam int WAIT_C = 250 * KHZ / 1000;   // 10
    localparam int SLOT_C = 250 * KHZ / 1000;   // 10

    logic clk = 1'b0, rst = 1'b1;
    logic pwr_up = 1'b0, ce = 1'b0, no_ack = 1'b0, ack_rx = 1'b0, ack_pld = 1'b0, clr_lost = 1'b0;
    logic [7:0] setup = 8'h03;
    logic tx_start, rx_en, pop, tx_ds, rx_dr, max_rt;
    logic [3:0] retry_cnt, lost_cnt;
    int fifo_n = 0;
    logic fifo_ne;
    assign fifo_ne = (fifo_n > 0);

    always #2.5 clk = ~clk;

    arq_tx_ctrl #(.CLK_KHZ(KHZ)) dut_i (
        .clk(clk), .rst(rst), .pwr_up_i(pwr_up), .ce_i(ce), .fifo_ne_i(fifo_ne),
        .no_ack_i(no_ack), .ack_rx_i(ack_rx), .ack_pld_i(ack_pld), .retr_setup_i(setup),
        .clr_lost_i(clr_lost), .tx_start_o(tx_start), .rx_en_o(rx_en), .pop_o(pop),
        .tx_ds_o(tx_ds), .rx_dr_o(rx_dr), .max_rt_o(max_rt), .retry_cnt_o(retry_cnt),
        .lost_cnt_o(lost_cnt)
    );

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit done = 0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference, advanced on each rising edge
    int  m_phase = 0, m_left = 0, m_retry = 0, m_lost = 0;
    bit  e_start, e_ds, e_dr, e_mrt, e_pop;
    always @(posedge clk) begin
        bit bump;
        bump = 0;
        cyc++;
        {e_start, e_ds, e_dr, e_mrt, e_pop} = '0;
        if (rst) begin
            m_phase = 0; m_left = 0; m_retry = 0; m_lost = 0;
        end else begin
            if (!pwr_up) m_phase = 0;
            else if (m_phase == 0) begin
                if (ce && fifo_n > 0) begin m_phase = 1; m_left = SET_C; m_retry = 0; end
            end else if (m_left > 1 && !(m_phase == 4 && ack_rx)) m_left--;
            else case (m_phase)
                1: begin m_phase = 2; m_left = AIR_C; e_start = 1; end
                2: if (no_ack) begin m_phase = 0; e_ds = 1; e_pop = 1; end
                   else begin m_phase = 3; m_left = SET_C; end
                3: begin m_phase = 4; m_left = WAIT_C; end
                4: if (ack_rx) begin m_phase = 0; e_ds = 1; e_pop = 1; e_dr = ack_pld; end
                   else if (m_retry == int'(setup[3:0])) begin m_phase = 0; e_mrt = 1; bump = 1; end
                   else begin m_retry++; m_phase = 5; m_left = (int'(setup[7:4]) + 1) * SLOT_C; end
                5: begin m_phase = 1; m_left = SET_C; end
                default: m_phase = 0;
            endcase
            if (clr_lost) m_lost = 0;
            else if (bump && m_lost < 15) m_lost++;
        end
    end

    // ---------------- per-cycle comparison and event bookkeeping
    int n_start = 0, n_ds = 0, n_dr = 0, n_mrt = 0, n_pop = 0, n_pair = 0, n_rxen = 0;
    int st_times[$];
    always @(negedge clk) begin
        if (!rst) begin
            chk("R2", "tx_start", int'(tx_start), int'(e_start));
            chk("R3", "rx_en", int'(rx_en), int'(m_phase == 3 || m_phase == 4));
            chk("R4", "pop", int'(pop), int'(e_pop));
            chk("R4", "tx_ds", int'(tx_ds), int'(e_ds));
            chk("R5", "rx_dr", int'(rx_dr), int'(e_dr));
            chk("R7", "max_rt", int'(max_rt), int'(e_mrt));
            chk("R6", "retry_cnt", int'(retry_cnt), m_retry);
            chk("R9", "lost_cnt", int'(lost_cnt), m_lost);
            if (tx_start) begin n_start++; st_times.push_back(cyc); end
            if (tx_ds) n_ds++;
            if (rx_dr) n_dr++;
            if (tx_ds && rx_dr) n_pair++;
            if (max_rt) n_mrt++;
            if (rx_en) n_rxen++;
            if (e_pop) begin n_pop++; fifo_n--; end
        end
    end

    task automatic clear_counts();
        n_start = 0; n_ds = 0; n_dr = 0; n_mrt = 0; n_pop = 0; n_pair = 0; n_rxen = 0;
        st_times.delete();
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_phase(input int p);
        while (m_phase != p) @(negedge clk);
    endtask

    task automatic pulse_ack(input bit pld);
        ack_rx = 1; ack_pld = pld;
        @(negedge clk);
        ack_rx = 0; ack_pld = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int t0;
        wait_cyc(3);
        // R1: reset state
        chk("R1", "strobes", int'({tx_start, rx_en, pop, tx_ds, rx_dr, max_rt}), 0);
        chk("R1", "retry", int'(retry_cnt), 0);
        chk("R1", "lost", int'(lost_cnt), 0);
        rst = 0;

        // R12 / R2: gating of the start
        pwr_up = 1; fifo_n = 1; ce = 0;
        wait_cyc(20);
        chk("R12", "start with ce low", n_start, 0);
        pwr_up = 0; ce = 1;
        wait_cyc(20);
        chk("R2", "start with power down", n_start, 0);
        ce = 0; pwr_up = 1;
        wait_cyc(2);

        // R2 / R4: empty acknowledgement
        clear_counts();
        ce = 1; t0 = cyc;
        while (n_start == 0) @(negedge clk);
        chk("R2", "ce to tx_start cycles", st_times[0] - t0, SET_C + 1);
        wait_phase(4); wait_cyc(3); pulse_ack(0);
        wait_cyc(3);
        chk("R4", "done count", n_ds, 1);
        chk("R4", "pop count", n_pop, 1);
        chk("R4", "rx event count", n_dr, 0);
        chk("R3", "rx_en cycles", n_rxen, SET_C + 4);

        // R5: acknowledgement with payload
        clear_counts(); fifo_n = 1;
        wait_phase(4); wait_cyc(1); pulse_ack(1);
        wait_cyc(3);
        chk("R5", "paired events", n_pair, 1);

        // R6: one miss, back-off of 3 slots, then acknowledged
        clear_counts(); setup = 8'h23; fifo_n = 1;
        wait_phase(5); wait_phase(4); pulse_ack(0);
        wait_cyc(2);
        chk("R6", "transmissions", n_start, 2);
        chk("R6", "retransmit gap", st_times[1] - st_times[0], AIR_C + SET_C + WAIT_C + 3 * SLOT_C + SET_C);
        chk("R6", "retry counter", int'(retry_cnt), 1);
        ce = 0;

        // R7: limit of 2 retries exhausted
        clear_counts(); setup = 8'h12; fifo_n = 1; ce = 1;
        wait_phase(1); ce = 0;
        while (n_mrt == 0) @(negedge clk);
        wait_cyc(3);
        chk("R7", "transmissions", n_start, 3);
        chk("R7", "pops", n_pop, 0);
        chk("R7", "lost", int'(lost_cnt), 1);

        // R8: limit 0, no retransmission
        clear_counts(); setup = 8'h00; ce = 1;
        wait_phase(1); ce = 0;
        while (n_mrt == 0) @(negedge clk);
        wait_cyc(3);
        chk("R8", "transmissions", n_start, 1);
        chk("R8", "lost", int'(lost_cnt), 2);

        // R13: retry counter restarts for the next packet
        clear_counts(); setup = 8'h13; ce = 1;
        wait_phase(1); ce = 0;
        chk("R13", "retry at start", int'(retry_cnt), 0);
        wait_phase(4); pulse_ack(0);
        wait_cyc(3);

        // R10: no-ack packet
        clear_counts(); no_ack = 1; fifo_n = 1; ce = 1;
        while (n_ds == 0) @(negedge clk);
        ce = 0; wait_cyc(3);
        chk("R10", "rx_en cycles", n_rxen, 0);
        chk("R10", "done count", n_ds, 1);
        no_ack = 0;

        // R11: power-down abort during back-off
        setup = 8'h53; fifo_n = 1; ce = 1;
        wait_phase(1); ce = 0;
        wait_phase(5); wait_cyc(2);
        clear_counts(); pwr_up = 0;
        wait_cyc(90);
        chk("R11", "events after abort", n_ds + n_mrt + n_start, 0);
        chk("R11", "rx_en after abort", n_rxen, 0);
        pwr_up = 1; fifo_n = 0; wait_cyc(2);

        // R12: back-to-back drain
        clear_counts(); no_ack = 1; fifo_n = 3; ce = 1;
        while (n_ds < 3) @(negedge clk);
        wait_cyc(20);
        chk("R12", "done count", n_ds, 3);
        chk("R12", "starts", n_start, 3);
        chk("R12", "start spacing", st_times[1] - st_times[0], AIR_C + 1 + SET_C);
        ce = 0; no_ack = 0;

        // R9: saturation and clear
        clear_counts(); setup = 8'h00; fifo_n = 1; ce = 1;
        while (n_mrt < 16) @(negedge clk);
        ce = 0; wait_phase(0); wait_cyc(5);
        chk("R9", "saturated lost", int'(lost_cnt), 15);
        clr_lost = 1; @(negedge clk); clr_lost = 0;
        chk("R9", "cleared lost", int'(lost_cnt), 0);
        wait_cyc(5);
        finish_run();
    end
endmodule